// File: doc/BRIEF.md
# Redundant Two-Stage Pipeline Converter Result Merger

This block sits behind the analog part of a 10-bit pipelined converter that serves a 64-channel readout chip. Two front-end stages, each with three quantisation levels, resolve the coarse part of a sample. An 8-bit back-end converter digitises the amplified residue. Each front-end stage reports a 2-bit thermometer code, and those codes are produced earlier than the back-end result for the same sample. The block decodes each thermometer code to a digit of 0, 1 or 2. It delays the first-stage digit further than the second-stage digit, so that both meet the back-end code of their own sample. It then sums the three parts with a one-bit overlap. Because of this overlap, a comparator that trips somewhat early or late only moves weight between neighbouring terms, so no calibration is needed.

One merged 10-bit result leaves the block on every clock. Each result carries the channel number that entered with the sample, a valid strobe, a per-sample error bit for a forbidden thermometer code, and an end-of-scan pulse on the result for the last channel. A two-state machine keeps a sticky error indication. Its state ERR_CLEAN moves to ERR_HELD on the first valid sample that carries a forbidden code. ERR_HELD stays where it is until reset, which is the only way back to ERR_CLEAN.

Top module: `pipe_adc_merge`

## Requirements
- R1: Each stage thermometer code decodes as 2'b00 to digit 0, 2'b01 to digit 1 and 2'b11 to digit 2.
- R2: The code 2'b10 on either stage is forbidden. It is decoded as digit 1, and the result of that sample has out_err set to 1.
- R3: The result is out_code = 256*D1 + 128*D2 + C, where D1 and D2 are the first-stage and second-stage digits and C is the unsigned back-end code.
- R4: With default parameters, a sample's in_valid, in_chan and s1_therm are presented in cycle t, its s2_therm in cycle t+1 and its be_code in cycle t+3. Its result is visible after the fourth rising edge, counting the edge that ends cycle t as the first.
- R5: Back-to-back valid samples give back-to-back results, one per clock. A cycle without in_valid gives a cycle with out_valid low, four edges later.
- R6: out_chan equals the in_chan presented with the same sample.
- R7: err_sticky rises on the same edge as the first result with out_err set, and stays high until reset.
- R8: out_eos is 1 only together with a valid result whose channel is 63 (NUM_CH-1), and is 0 otherwise.
- R9: Reset clears out_valid, out_eos, out_err and err_sticky. Samples that were in flight when reset was applied never emerge as results.
- R10: Forbidden codes that line up with a slot where no sample is valid have no effect: out_err stays 0 and err_sticky does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new sample starts in this cycle |
| in_chan | input | 6 | Channel number of the starting sample |
| s1_therm | input | 2 | First-stage thermometer code of the starting sample |
| s2_therm | input | 2 | Second-stage thermometer code, one cycle after the sample starts |
| be_code | input | 8 | Back-end code, three cycles after the sample starts |
| out_valid | output | 1 | A merged result is present |
| out_code | output | 10 | Merged 10-bit result |
| out_chan | output | 6 | Channel number of the result |
| out_err | output | 1 | The result used a forbidden stage code |
| out_eos | output | 1 | The result belongs to the last channel of a scan |
| err_sticky | output | 1 | A forbidden code has been seen since reset |

## Verification
Every combination of the two legal stage digits is swept against all 256 back-end codes in an unbroken stream. This separates a wrong weight or a missing overlap bit in the adder from a misalignment, because a misaligned stage would take its digit from the neighbouring sample. Gaps are inserted into the stream at regular intervals, and their slots carry forbidden codes. This shows whether valid and channel tags travel in step with the data, and whether errors outside a sample are ignored. A later section mixes forbidden codes into valid samples on each stage alone and on both stages. After that, reset is applied with samples still in the pipeline, and one fresh last-channel sample after reset checks that results are produced again.

// File: rtl/pipe_adc_merge_pkg.sv
package pipe_adc_merge_pkg;

    typedef enum logic [0:0] {
        ERR_CLEAN = 1'b0,
        ERR_HELD  = 1'b1
    } err_state_t;

    localparam logic [1:0] THERM_LOW  = 2'b00;
    localparam logic [1:0] THERM_MID  = 2'b01;
    localparam logic [1:0] THERM_HIGH = 2'b11;
    localparam logic [1:0] THERM_BAD  = 2'b10;

endpackage

// File: rtl/pipe_adc_stage_dec.sv
module pipe_adc_stage_dec
    import pipe_adc_merge_pkg::*;
(
    input  logic [1:0] therm,
    output logic [1:0] digit,
    output logic       bad
);

    always_comb begin
        unique case (therm)
            THERM_LOW:  begin digit = 2'd0; bad = 1'b0; end
            THERM_MID:  begin digit = 2'd1; bad = 1'b0; end
            THERM_HIGH: begin digit = 2'd2; bad = 1'b0; end
            THERM_BAD:  begin digit = 2'd1; bad = 1'b1; end
        endcase
    end

endmodule

// File: rtl/pipe_adc_delay.sv
module pipe_adc_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] taps [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        taps[i] <= '0;
                    end
                end else begin
                    taps[0] <= d;
                    for (int i = 1; i < DEPTH; i++) begin
                        taps[i] <= taps[i-1];
                    end
                end
            end

            assign q = taps[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pipe_adc_err_fsm.sv
module pipe_adc_err_fsm
    import pipe_adc_merge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic sticky
);

    err_state_t state;
    err_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ERR_CLEAN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        sticky    = 1'b0;
        unique case (state)
            ERR_CLEAN: begin
                if (hit) begin
                    state_nxt = ERR_HELD;
                end
            end
            ERR_HELD: begin
                sticky = 1'b1;
            end
        endcase
    end

    // R7: once held, the flag never drops without reset
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sticky |=> sticky);

endmodule

// File: rtl/pipe_adc_merge.sv
module pipe_adc_merge #(
    parameter int BE_W   = 8,
    parameter int CH_W   = 6,
    parameter int S1_LAG = 3,
    parameter int S2_LAG = 2,
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [1:0]        s1_therm,
    input  logic [1:0]        s2_therm,
    input  logic [BE_W-1:0]   be_code,
    output logic              out_valid,
    output logic [BE_W+1:0]   out_code,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_err,
    output logic              out_eos,
    output logic              err_sticky
);

    localparam int OUT_W   = BE_W + 2;
    localparam int LAST_CH = NUM_CH - 1;
    localparam int P1_W    = 1 + CH_W + 2 + 1;
    localparam int P2_W    = 2 + 1;

    // stage decode
    logic [1:0] d1_now;
    logic [1:0] d2_now;
    logic       bad1_now;
    logic       bad2_now;

    pipe_adc_stage_dec u_dec1 (.therm(s1_therm), .digit(d1_now), .bad(bad1_now));
    pipe_adc_stage_dec u_dec2 (.therm(s2_therm), .digit(d2_now), .bad(bad2_now));

    // alignment: first stage carries valid and channel tag
    logic [P1_W-1:0] p1_in;
    logic [P1_W-1:0] p1_out;
    logic [P2_W-1:0] p2_in;
    logic [P2_W-1:0] p2_out;

    assign p1_in = {in_valid, in_chan, d1_now, bad1_now};
    assign p2_in = {d2_now, bad2_now};

    pipe_adc_delay #(.W(P1_W), .DEPTH(S1_LAG)) u_dly1 (
        .clk(clk), .rst_n(rst_n), .d(p1_in), .q(p1_out)
    );
    pipe_adc_delay #(.W(P2_W), .DEPTH(S2_LAG)) u_dly2 (
        .clk(clk), .rst_n(rst_n), .d(p2_in), .q(p2_out)
    );

    logic            al_valid;
    logic [CH_W-1:0] al_chan;
    logic [1:0]      al_d1;
    logic [1:0]      al_d2;
    logic            al_bad1;
    logic            al_bad2;
    logic            al_err;
    logic            al_last;

    assign {al_valid, al_chan, al_d1, al_bad1} = p1_out;
    assign {al_d2, al_bad2}                    = p2_out;
    assign al_err  = al_valid & (al_bad1 | al_bad2);
    assign al_last = al_valid && (al_chan == CH_W'(LAST_CH));

    // overlapped sum: stage weights overlap the back-end by one bit
    logic [OUT_W-1:0] w1;
    logic [OUT_W-1:0] w2;
    logic [OUT_W-1:0] wc;
    logic [OUT_W-1:0] merged;

    assign w1     = OUT_W'(al_d1) << BE_W;
    assign w2     = OUT_W'(al_d2) << (BE_W - 1);
    assign wc     = OUT_W'(be_code);
    assign merged = w1 + w2 + wc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
            out_chan  <= '0;
            out_err   <= 1'b0;
            out_eos   <= 1'b0;
        end else begin
            out_valid <= al_valid;
            out_code  <= merged;
            out_chan  <= al_chan;
            out_err   <= al_err;
            out_eos   <= al_last;
        end
    end

    pipe_adc_err_fsm u_err (
        .clk(clk), .rst_n(rst_n), .hit(al_err), .sticky(err_sticky)
    );

    // R7: a flagged result is always covered by the sticky flag
    a_r7_err_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> err_sticky);

    // R8: end of scan only on a valid last-channel result
    a_r8_eos_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_eos |-> (out_valid && out_chan == CH_W'(LAST_CH)));

    // R10: no error reported outside a valid result
    a_r10_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);

    // R3: a valid result is fully defined
    a_r3_code_known: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_code));

endmodule

// File: tb/pipe_adc_merge_test.sv
module pipe_adc_merge_test;

    localparam int NC = 2720;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] in_chan = '0;
    logic [1:0] s1_therm = '0;
    logic [1:0] s2_therm = '0;
    logic [7:0] be_code = '0;
    logic       out_valid;
    logic [9:0] out_code;
    logic [5:0] out_chan;
    logic       out_err;
    logic       out_eos;
    logic       err_sticky;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit         v_a  [NC];
    int         ch_a [NC];
    logic [1:0] s1_a [NC];
    logic [1:0] s2_a [NC];
    logic [7:0] be_a [NC];

    always #4 clk = ~clk;

    pipe_adc_merge uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .s1_therm(s1_therm), .s2_therm(s2_therm), .be_code(be_code),
        .out_valid(out_valid), .out_code(out_code), .out_chan(out_chan),
        .out_err(out_err), .out_eos(out_eos), .err_sticky(err_sticky)
    );

    function automatic logic [1:0] to_therm(int d);
        return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b11;
    endfunction

    // R1/R2 decode, computed from the requirement table
    function automatic int digit_of(logic [1:0] t);
        if (t == 2'b00) return 0;
        if (t == 2'b11) return 2;
        return 1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int k;
        bit exp_sticky;
        k = 0;
        exp_sticky = 0;
        for (int c = 0; c < NC; c++) begin
            v_a[c] = !((c % 23) == 22 || (c >= 1000 && c < 1005));
            if (v_a[c]) begin
                ch_a[c] = k % 64;
                if (k < 2304) begin
                    s1_a[c] = to_therm(k / 768);
                    s2_a[c] = to_therm((k / 256) % 3);
                    be_a[c] = 8'(k % 256);
                end else begin
                    s1_a[c] = 2'(k % 4);
                    s2_a[c] = 2'((k / 4) % 4);
                    be_a[c] = 8'((k * 29 + 11) % 256);
                end
                k++;
            end else begin
                // R10: forbidden codes in empty slots
                ch_a[c] = 0;
                s1_a[c] = 2'b10;
                s2_a[c] = 2'b10;
                be_a[c] = 8'hAA;
            end
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: state after reset
        check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        check(out_eos == 1'b0, "R9", "out_eos after reset", int'(out_eos), 0);
        check(err_sticky == 1'b0, "R9", "err_sticky after reset", int'(err_sticky), 0);

        for (int cyc = 0; cyc < NC + 4; cyc++) begin
            @(negedge clk);
            if (cyc >= 4) begin
                int j;
                j = cyc - 4;
                if (v_a[j]) begin
                    int d1;
                    int d2;
                    int ec;
                    bit ee;
                    d1 = digit_of(s1_a[j]);
                    d2 = digit_of(s2_a[j]);
                    ec = 256 * d1 + 128 * d2 + int'(be_a[j]);
                    ee = (s1_a[j] == 2'b10) || (s2_a[j] == 2'b10);
                    exp_sticky = exp_sticky | ee;
                    check(out_valid == 1'b1, "R5", "out_valid", int'(out_valid), 1);
                    // R1 R3 R4: merged value of the aligned sample
                    check(int'(out_code) == ec, "R3", "out_code", int'(out_code), ec);
                    check(int'(out_chan) == ch_a[j], "R6", "out_chan", int'(out_chan), ch_a[j]);
                    check(out_err == ee, "R2", "out_err", int'(out_err), int'(ee));
                    check(out_eos == (ch_a[j] == 63), "R8", "out_eos", int'(out_eos),
                          int'(ch_a[j] == 63));
                end else begin
                    check(out_valid == 1'b0, "R5", "out_valid in gap", int'(out_valid), 0);
                    check(out_err == 1'b0, "R10", "out_err in gap", int'(out_err), 0);
                    check(out_eos == 1'b0, "R8", "out_eos in gap", int'(out_eos), 0);
                end
                check(err_sticky == exp_sticky, "R7", "err_sticky", int'(err_sticky),
                      int'(exp_sticky));
            end
            in_valid = (cyc < NC) ? v_a[cyc] : 1'b0;
            in_chan  = (cyc < NC) ? 6'(ch_a[cyc]) : 6'd0;
            s1_therm = (cyc < NC) ? s1_a[cyc] : 2'b00;
            s2_therm = (cyc >= 1 && cyc - 1 < NC) ? s2_a[cyc-1] : 2'b00;
            be_code  = (cyc >= 3 && cyc - 3 < NC) ? be_a[cyc-3] : 8'd0;
        end

        // R9: reset with samples in flight
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_chan  = 6'd63;
            s1_therm = 2'b10;
            s2_therm = 2'b10;
        end
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_chan  = '0;
        s1_therm = '0;
        s2_therm = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", "out_valid after flush", int'(out_valid), 0);
            check(err_sticky == 1'b0, "R9", "err_sticky after flush", int'(err_sticky), 0);
        end

        // R4 R8: one last-channel sample after reset
        in_valid = 1'b1;
        in_chan  = 6'd63;
        s1_therm = 2'b11;
        @(negedge clk);
        in_valid = 1'b0;
        in_chan  = '0;
        s1_therm = '0;
        s2_therm = 2'b01;
        @(negedge clk);
        s2_therm = '0;
        @(negedge clk);
        be_code = 8'h3F;
        @(negedge clk);
        be_code = '0;
        check(out_valid == 1'b1, "R4", "out_valid after restart", int'(out_valid), 1);
        check(int'(out_code) == 703, "R4", "out_code after restart", int'(out_code), 703);
        check(out_eos == 1'b1, "R8", "out_eos after restart", int'(out_eos), 1);
        check(err_sticky == 1'b0, "R7", "err_sticky after restart", int'(err_sticky), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule